// File: doc/BRIEF.md
# Chunked Stride DMA Address Generator

This block produces the address stream for one DMA channel transfer. A transfer is described by a start source address, a start destination address, a total byte count, a common chunk length, and a signed skip for each side. The byte stream is cut into chunks of the common length. After each chunk, each side jumps by its own signed skip. A negative skip lets a side walk backwards through memory. A side whose increment enable is clear stays on one address for the whole transfer, which suits a peripheral data register.

While a transfer runs, the block emits one beat per clock. Each beat carries a source address, a destination address and a byte length. The length is limited by the burst size, which is given as a log2 exponent. A beat never crosses a chunk boundary. The next source and destination addresses are always visible as status. A single-cycle done pulse marks the final beat.

Top module: `chunked_stride_agen`

## Requirements
- R1: Asserting `start` loads every parameter. In the following cycle, `cur_src`/`cur_dst` equal the start addresses and `busy` is 1 exactly when `xfer_size` is nonzero.
- R2: While busy, a beat (`beat_valid`=1) is emitted every cycle. Its length is the minimum of 2^`burst_log`, the bytes left in the current chunk and the bytes left in the transfer.
- R3: With `chunk_len`=0 there is no chunking. Each beat address is the previous one plus the previous beat length, and the whole size goes out as one run.
- R4: At each chunk boundary, an incrementing side's next address is the address after the chunk's last byte plus that side's skip. The skip is a two's-complement `ADDR_W`-bit value, and negative values move the address backwards.
- R5: The final chunk may be shorter than `chunk_len`. Skips are applied ceil(size/chunk)-1 times, so no skip follows the last chunk. After the last beat, an incrementing side's `cur_*` equals that beat's address plus its length.
- R6: A side with its increment enable at 0 presents its start address on every beat and in `cur_*`, and its skip is ignored.
- R7: `done` is high for exactly one cycle, in the same cycle as the final beat. With `xfer_size`=0, `done` rises in the cycle after `start` and no beat is emitted.
- R8: A `start` during a running transfer abandons that transfer and begins the new one, with the same timing as from idle.
- R9: During a transfer, `cur_src`/`cur_dst` always hold the address that the next beat of that side will carry.
- R10: After reset, `busy`, `done`, `beat_valid` and both `cur_*` outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Load parameters and begin a transfer |
| src_base | input | ADDR_W | Source start address |
| dst_base | input | ADDR_W | Destination start address |
| xfer_size | input | SIZE_W | Total bytes |
| chunk_len | input | SIZE_W | Common chunk length, 0 = unchunked |
| src_skip | input | ADDR_W | Signed source gap |
| dst_skip | input | ADDR_W | Signed destination gap |
| src_inc | input | 1 | Source address increments |
| dst_inc | input | 1 | Destination address increments |
| burst_log | input | BLOG_W | log2 of burst bytes |
| beat_valid | output | 1 | Beat outputs are valid |
| beat_src | output | ADDR_W | Beat source address |
| beat_dst | output | ADDR_W | Beat destination address |
| beat_len | output | SIZE_W | Beat byte count |
| done | output | 1 | Final-beat pulse |
| busy | output | 1 | Transfer in progress |
| cur_src | output | ADDR_W | Next source address status |
| cur_dst | output | ADDR_W | Next destination address status |

## Verification
The bench sweeps sizes, chunk lengths, positive, zero and negative skips, burst exponents and increment settings. For every beat it derives the expected addresses and length from the byte offset alone.

Each sweep targets a specific mistake:
- Sizes that are not a multiple of the chunk length. A design that let a beat straddle a chunk boundary, or that added a skip after the final chunk, would show a wrong length or a wrong end status.
- Negative skips whose magnitude exceeds the chunk length. These catch an unsigned or sign-truncated skip add.
- Fixed-address sides with nonzero skips. These catch a design that still applied the gap when the side does not increment.
- Zero-size transfers and restarts in mid-transfer. These catch a stuck `busy`, a missing or doubled `done`, and state left over from the abandoned transfer.

// File: rtl/dma_agen_pkg.sv
package dma_agen_pkg;
  localparam int BLOG_W = 3;

  function automatic logic [31:0] umin32(input logic [31:0] a, input logic [31:0] b);
    return (a < b) ? a : b;
  endfunction
endpackage

// File: rtl/dma_agen_count.sv
module dma_agen_count #(
  parameter int SIZE_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [SIZE_W-1:0] size_in,
  input  logic [SIZE_W-1:0] chunk_in,
  input  logic              step,
  input  logic [SIZE_W-1:0] len,
  input  logic              wrap,
  input  logic              last,
  output logic [SIZE_W-1:0] rem,
  output logic [SIZE_W-1:0] cleft,
  output logic              busy
);
  logic [SIZE_W-1:0] chunk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rem     <= '0;
      cleft   <= '0;
      chunk_q <= '0;
      busy    <= 1'b0;
    end else if (load) begin
      rem     <= size_in;
      cleft   <= (chunk_in == '0) ? size_in : chunk_in;
      chunk_q <= chunk_in;
      busy    <= (size_in != '0);
    end else if (step) begin
      rem   <= rem - len;
      cleft <= wrap ? chunk_q : (cleft - len);
      busy  <= !last;
    end
  end
endmodule

// File: rtl/dma_agen_beat.sv
module dma_agen_beat #(
  parameter int SIZE_W = 16,
  parameter int BLOG_W = 3
) (
  input  logic [BLOG_W-1:0] blog,
  input  logic [SIZE_W-1:0] rem,
  input  logic [SIZE_W-1:0] cleft,
  output logic [SIZE_W-1:0] len,
  output logic              last,
  output logic              wrap
);
  import dma_agen_pkg::*;
  logic [31:0] burst_bytes;
  logic [31:0] lim;

  always_comb begin
    burst_bytes = 32'd1 << blog;
    lim  = umin32(umin32(burst_bytes, 32'(cleft)), 32'(rem));
    len  = SIZE_W'(lim);
    last = (len == rem);
    wrap = (len == cleft) && !last;
  end
endmodule

// File: rtl/dma_agen_side.sv
module dma_agen_side #(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] base_in,
  input  logic [ADDR_W-1:0] skip_in,
  input  logic              inc_in,
  input  logic              step,
  input  logic [SIZE_W-1:0] len,
  input  logic              wrap,
  output logic [ADDR_W-1:0] cur,
  output logic              inc_o
);
  logic [ADDR_W-1:0] skip_q;
  logic [ADDR_W-1:0] nxt;

  always_comb begin
    nxt = cur + ADDR_W'(len) + (wrap ? skip_q : '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur    <= '0;
      skip_q <= '0;
      inc_o  <= 1'b0;
    end else if (load) begin
      cur    <= base_in;
      skip_q <= skip_in;
      inc_o  <= inc_in;
    end else if (step && inc_o) begin
      cur <= nxt;
    end
  end
endmodule

// File: rtl/chunked_stride_agen.sv
module chunked_stride_agen #(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 16,
  parameter int BLOG_W = dma_agen_pkg::BLOG_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic [ADDR_W-1:0]        src_base,
  input  logic [ADDR_W-1:0]        dst_base,
  input  logic [SIZE_W-1:0]        xfer_size,
  input  logic [SIZE_W-1:0]        chunk_len,
  input  logic signed [ADDR_W-1:0] src_skip,
  input  logic signed [ADDR_W-1:0] dst_skip,
  input  logic                     src_inc,
  input  logic                     dst_inc,
  input  logic [BLOG_W-1:0]        burst_log,
  output logic                     beat_valid,
  output logic [ADDR_W-1:0]        beat_src,
  output logic [ADDR_W-1:0]        beat_dst,
  output logic [SIZE_W-1:0]        beat_len,
  output logic                     done,
  output logic                     busy,
  output logic [ADDR_W-1:0]        cur_src,
  output logic [ADDR_W-1:0]        cur_dst
);
  logic [BLOG_W-1:0] burst_q;
  logic [SIZE_W-1:0] rem, cleft, len;
  logic              last, wrap, step;
  logic              src_inc_q, dst_inc_q;

  assign step = busy && !start;

  dma_agen_count #(.SIZE_W(SIZE_W)) u_count (
    .clk(clk), .rst(rst), .load(start), .size_in(xfer_size), .chunk_in(chunk_len),
    .step(step), .len(len), .wrap(wrap), .last(last),
    .rem(rem), .cleft(cleft), .busy(busy)
  );

  dma_agen_beat #(.SIZE_W(SIZE_W), .BLOG_W(BLOG_W)) u_beat (
    .blog(burst_q), .rem(rem), .cleft(cleft), .len(len), .last(last), .wrap(wrap)
  );

  dma_agen_side #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_src (
    .clk(clk), .rst(rst), .load(start), .base_in(src_base), .skip_in(src_skip),
    .inc_in(src_inc), .step(step), .len(len), .wrap(wrap), .cur(cur_src), .inc_o(src_inc_q)
  );

  dma_agen_side #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_dst (
    .clk(clk), .rst(rst), .load(start), .base_in(dst_base), .skip_in(dst_skip),
    .inc_in(dst_inc), .step(step), .len(len), .wrap(wrap), .cur(cur_dst), .inc_o(dst_inc_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      burst_q    <= '0;
      beat_valid <= 1'b0;
      beat_src   <= '0;
      beat_dst   <= '0;
      beat_len   <= '0;
      done       <= 1'b0;
    end else begin
      if (start) burst_q <= burst_log;
      beat_valid <= step;
      if (step) begin
        beat_src <= cur_src;
        beat_dst <= cur_dst;
        beat_len <= len;
      end
      done <= start ? (xfer_size == '0) : (step && last);
    end
  end
endmodule

// File: rtl/chunked_stride_agen_chk.sv
module chunked_stride_agen_chk #(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              beat_valid,
  input logic [SIZE_W-1:0] beat_len,
  input logic              done,
  input logic              busy,
  input logic [ADDR_W-1:0] cur_src,
  input logic [ADDR_W-1:0] cur_dst,
  input logic              src_inc_q,
  input logic              dst_inc_q
);
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done && !start |=> !done);
  // R2
  beat_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    beat_valid |-> beat_len != '0);
  // R2
  beat_from_busy_chk: assert property (@(posedge clk) disable iff (rst)
    beat_valid |-> $past(busy));
  // R7
  busy_ends_done_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> (busy || done));
  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !busy && !start |=> !beat_valid);
  // R6
  src_fixed_chk: assert property (@(posedge clk) disable iff (rst)
    busy && !start && !src_inc_q |=> $stable(cur_src));
  // R6
  dst_fixed_chk: assert property (@(posedge clk) disable iff (rst)
    busy && !start && !dst_inc_q |=> $stable(cur_dst));
endmodule

bind chunked_stride_agen chunked_stride_agen_chk #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .beat_valid(beat_valid), .beat_len(beat_len),
  .done(done), .busy(busy), .cur_src(cur_src), .cur_dst(cur_dst),
  .src_inc_q(src_inc_q), .dst_inc_q(dst_inc_q)
);

// File: tb/chunked_stride_agen_bench.sv
module chunked_stride_agen_bench;
  localparam int AW = 32;
  localparam int SW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [AW-1:0] src_base = '0, dst_base = '0;
  logic [SW-1:0] xfer_size = '0, chunk_len = '0;
  logic signed [AW-1:0] src_skip = '0, dst_skip = '0;
  logic src_inc = 1'b0, dst_inc = 1'b0;
  logic [2:0] burst_log = '0;
  logic beat_valid, done, busy;
  logic [AW-1:0] beat_src, beat_dst, cur_src, cur_dst;
  logic [SW-1:0] beat_len;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  chunked_stride_agen #(.ADDR_W(AW), .SIZE_W(SW)) u_chunked_stride_agen (
    .clk(clk), .rst(rst), .start(start), .src_base(src_base), .dst_base(dst_base),
    .xfer_size(xfer_size), .chunk_len(chunk_len), .src_skip(src_skip), .dst_skip(dst_skip),
    .src_inc(src_inc), .dst_inc(dst_inc), .burst_log(burst_log),
    .beat_valid(beat_valid), .beat_src(beat_src), .beat_dst(beat_dst), .beat_len(beat_len),
    .done(done), .busy(busy), .cur_src(cur_src), .cur_dst(cur_dst)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] eaddr(input logic [AW-1:0] base, input int o,
                                          input int ch, input logic [AW-1:0] skip, input bit inc);
    int idx;
    if (!inc) return base;
    idx = (ch == 0) ? 0 : o / ch;
    return base + AW'(o) + AW'(idx) * skip;
  endfunction

  task automatic drive_start(input int sz, input int ch, input int ss, input int ds,
                             input bit si, input bit di, input int bl,
                             input logic [AW-1:0] sb, input logic [AW-1:0] db);
    @(negedge clk);
    start = 1'b1; xfer_size = SW'(sz); chunk_len = SW'(ch);
    src_skip = AW'(ss); dst_skip = AW'(ds); src_inc = si; dst_inc = di;
    burst_log = 3'(bl); src_base = sb; dst_base = db;
    @(negedge clk);
    start = 1'b0;
    // R1 / R8: load visible one cycle after start
    chk(cur_src == sb, "R1 cur_src after start", cur_src, sb);
    chk(cur_dst == db, "R1 cur_dst after start", cur_dst, db);
    chk(busy == (sz != 0), "R1 busy after start", busy, sz != 0);
    if (sz == 0) begin
      chk(done == 1'b1 && beat_valid == 1'b0, "R7 zero size done", done, 1);
      @(negedge clk);
      chk(done == 1'b0 && busy == 1'b0 && beat_valid == 1'b0, "R7 zero size pulse ends", done, 0);
    end
  endtask

  task automatic run_beats(input int sz, input int ch, input int ss, input int ds,
                           input bit si, input bit di, input int bl,
                           input logic [AW-1:0] sb, input logic [AW-1:0] db);
    int o = 0;
    int burst = 1 << bl;
    while (o < sz) begin
      int cl, L;
      logic [AW-1:0] es, ed, ns, nd;
      @(negedge clk);
      cl = (ch == 0) ? (sz - o) : (ch - (o % ch));
      L = burst;
      if (cl < L) L = cl;
      if (sz - o < L) L = sz - o;
      es = eaddr(sb, o, ch, AW'(ss), si);
      ed = eaddr(db, o, ch, AW'(ds), di);
      if (o + L < sz) begin
        ns = eaddr(sb, o + L, ch, AW'(ss), si);
        nd = eaddr(db, o + L, ch, AW'(ds), di);
      end else begin
        // R5: no trailing skip after the last chunk
        ns = si ? es + AW'(L) : sb;
        nd = di ? ed + AW'(L) : db;
      end
      chk(beat_valid == 1'b1, "R2 beat_valid", beat_valid, 1);
      chk(beat_len == SW'(L), "R2 beat_len", beat_len, L);
      chk(beat_src == es, "R4/R6 beat_src", beat_src, es);
      chk(beat_dst == ed, "R4/R6 beat_dst", beat_dst, ed);
      chk(done == (o + L == sz), "R7 done on final beat", done, o + L == sz);
      chk(cur_src == ns, "R9 cur_src next", cur_src, ns);
      chk(cur_dst == nd, "R9 cur_dst next", cur_dst, nd);
      o += L;
    end
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0 && beat_valid == 1'b0, "R7 idle after final beat", done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(busy == 0 && done == 0 && beat_valid == 0, "R10 reset flags", {busy, done, beat_valid}, 0);
    chk(cur_src == 0 && cur_dst == 0, "R10 reset addresses", cur_src, 0);
    rst = 1'b0;

    // R3 / R4 / R5 / R6: sweep
    for (int bl = 0; bl < 3; bl++) begin
      for (int ci = 0; ci < 4; ci++) begin
        for (int ki = 0; ki < 4; ki++) begin
          for (int sz = 0; sz <= 18; sz++) begin
            int ch = (ci == 0) ? 0 : (ci == 1) ? 3 : (ci == 2) ? 4 : 7;
            int ss = (ki == 0) ? 0 : (ki == 1) ? 5 : (ki == 2) ? -3 : -20;
            int ds = -ss + 2;
            bit si = ((sz + ki) % 3) != 0;
            bit di = ((sz + bl) % 4) != 1;
            logic [AW-1:0] sb = 32'h1000_0000 + AW'(sz * 16);
            logic [AW-1:0] db = 32'h0000_0040 + AW'(ki);
            drive_start(sz, ch, ss, ds, si, di, bl, sb, db);
            if (sz != 0) run_beats(sz, ch, ss, ds, si, di, bl, sb, db);
          end
        end
      end
    end

    // R2 / R3: large burst, unchunked
    drive_start(300, 0, 9, 9, 1, 1, 7, 32'hFFFF_FF00, 32'h0);
    run_beats(300, 0, 9, 9, 1, 1, 7, 32'hFFFF_FF00, 32'h0);

    // R8: restart mid-transfer
    drive_start(40, 0, 0, 0, 1, 1, 1, 32'h5000, 32'h6000);
    @(negedge clk);
    @(negedge clk);
    drive_start(10, 4, -12, 8, 1, 1, 2, 32'h7000, 32'h8000);
    run_beats(10, 4, -12, 8, 1, 1, 2, 32'h7000, 32'h8000);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule